// File: doc/BRIEF.md
# Sign-Steered Cross-Correlation Accumulator

This block keeps a running cross-correlation matrix between a vector of antipodal training or decision bits and a vector of complex received samples, over a sliding window. Each bit is either +1 or -1, so each bit-by-sample product is just the sample added or subtracted. No multiplier is needed. One update brings the newest bit and sample vectors into the matrix. In the same step it removes the contribution of the bit and sample vectors that are leaving the window.

The matrix has NBITS rows, one per bit, and NSAMP columns, one per sample. Each entry holds one complex value, with a real lane and an imaginary lane. One shared add/subtract datapath walks every (row, column) entry, doing one read-modify-write per cycle, and a busy flag stays high for the whole walk. A clear pass walks the matrix in the same way and writes zeros, which prepares the matrix before training begins. A read port lets a downstream estimator fetch any entry.

Top module: `sign_xcorr_acc`

## Requirements
- R1: After reset, busy is low and every entry reads zero in both lanes.
- R2: A valid pulse while idle starts a pass. Busy rises in the next cycle and stays high for exactly NBITS*NSAMP cycles.
- R3: The update changes entry (i,j) to old + s(newBits[i])*newSample[j] - s(oldBits[i])*oldSample[j]. Here s(1)=+1 and s(0)=-1. The real and imaginary lanes are computed separately with the same signs. Sample j sits at bits [j*W +: W] of each flat sample input.
- R4: Each lane's result is saturated to the W-bit signed range [-128, 127] for W=8. Saturation is applied to the full three-term sum.
- R5: A clear pulse while idle zeroes every entry. The clear pass has the same busy length as an update pass. If clear and valid arrive in the same cycle, clear wins.
- R6: Valid and clear pulses that arrive while busy is high are ignored. The bit and sample inputs are captured when a pass starts, so later changes to them do not affect the results.
- R7: The read port returns entry (rdRow, rdCol) without delay. While the block is idle and no pass is starting, the value read back does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Start an update pass |
| clear | input | 1 | Start a zeroing pass |
| newBits | input | NBITS | Bits entering the window (1 = +1) |
| oldBits | input | NBITS | Bits leaving the window |
| newRe | input | NSAMP*W | Real parts of the entering samples |
| newIm | input | NSAMP*W | Imaginary parts of the entering samples |
| oldRe | input | NSAMP*W | Real parts of the leaving samples |
| oldIm | input | NSAMP*W | Imaginary parts of the leaving samples |
| busy | output | 1 | High while a pass walks the matrix |
| rdRow | input | RW | Read row index |
| rdCol | input | CW | Read column index |
| rdRe | output | W | Real lane of the selected entry |
| rdIm | output | W | Imaginary lane of the selected entry |

## Verification
The assertions check the pass sequencing on every cycle: busy holds until the last cell and then drops, and the walk index rests at zero while idle. They also check that a clear write leaves a zero at the cell it touched, and that the read value stays stable while idle. The arithmetic needs the bench's scenarios to show it. That includes the sign-steered add and subtract, saturation at both limits, the ignored mid-pass pulses and clear winning over valid. The bench compares the whole matrix against its reference model after each pass.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
  typedef struct packed {
    logic load;
    logic wrEn;
    logic zero;
  } xc_strb_t;
endpackage

// File: rtl/xcorr_ctrl.sv
module xcorr_ctrl
  import xcorr_pkg::*;
#(
  parameter int NBITS = 4,
  parameter int NSAMP = 4,
  localparam int RW = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int CW = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          valid,
  input  logic          clear,
  output logic          busy,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col,
  output xc_strb_t      strb
);
  logic busyQ, zeroQ, lastCell;

  assign lastCell = (row == RW'(NBITS-1)) && (col == CW'(NSAMP-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      zeroQ <= 1'b0;
      row   <= '0;
      col   <= '0;
    end else if (!busyQ) begin
      row <= '0;
      col <= '0;
      if (clear) begin
        busyQ <= 1'b1;
        zeroQ <= 1'b1;
      end else if (valid) begin
        busyQ <= 1'b1;
        zeroQ <= 1'b0;
      end
    end else if (lastCell) begin
      busyQ <= 1'b0;
      row   <= '0;
      col   <= '0;
    end else if (col == CW'(NSAMP-1)) begin
      col <= '0;
      row <= row + 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  assign busy      = busyQ;
  assign strb.load = !busyQ && valid && !clear;
  assign strb.wrEn = busyQ;
  assign strb.zero = zeroQ;

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !lastCell) |=> busyQ);
  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && lastCell) |=> !busyQ);
  assert_idle_index_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> (row == '0 && col == '0));
endmodule

// File: rtl/xcorr_dp.sv
module xcorr_dp
  import xcorr_pkg::*;
#(
  parameter int NBITS = 4,
  parameter int NSAMP = 4,
  parameter int W     = 8,
  localparam int RW = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int CW = (NSAMP > 1) ? $clog2(NSAMP) : 1,
  localparam int XW = W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xc_strb_t             strb,
  input  logic [RW-1:0]        row,
  input  logic [CW-1:0]        col,
  input  logic [NBITS-1:0]     newBits,
  input  logic [NBITS-1:0]     oldBits,
  input  logic [NSAMP*W-1:0]   newRe,
  input  logic [NSAMP*W-1:0]   newIm,
  input  logic [NSAMP*W-1:0]   oldRe,
  input  logic [NSAMP*W-1:0]   oldIm,
  input  logic [RW-1:0]        rdRow,
  input  logic [CW-1:0]        rdCol,
  output logic signed [W-1:0]  rdRe,
  output logic signed [W-1:0]  rdIm
);
  localparam logic signed [XW-1:0] MAXV = XW'((1 <<< (W-1)) - 1);
  localparam logic signed [XW-1:0] MINV = -XW'(1 <<< (W-1));

  logic [NBITS-1:0] nBitQ, oBitQ;
  logic signed [W-1:0] nReQ [NSAMP];
  logic signed [W-1:0] nImQ [NSAMP];
  logic signed [W-1:0] oReQ [NSAMP];
  logic signed [W-1:0] oImQ [NSAMP];
  logic signed [W-1:0] memRe [NBITS][NSAMP];
  logic signed [W-1:0] memIm [NBITS][NSAMP];
  logic signed [W-1:0] nextRe, nextIm;

  function automatic logic signed [XW-1:0] steer(input logic b, input logic signed [W-1:0] x);
    logic signed [XW-1:0] e;
    e = XW'(x);
    return b ? e : -e;
  endfunction

  function automatic logic signed [W-1:0] clampLane(input logic signed [XW-1:0] v);
    if (v > MAXV) return MAXV[W-1:0];
    if (v < MINV) return MINV[W-1:0];
    return v[W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nBitQ <= '0;
      oBitQ <= '0;
      for (int j = 0; j < NSAMP; j++) begin
        nReQ[j] <= '0; nImQ[j] <= '0; oReQ[j] <= '0; oImQ[j] <= '0;
      end
    end else if (strb.load) begin
      nBitQ <= newBits;
      oBitQ <= oldBits;
      for (int j = 0; j < NSAMP; j++) begin
        nReQ[j] <= newRe[j*W +: W];
        nImQ[j] <= newIm[j*W +: W];
        oReQ[j] <= oldRe[j*W +: W];
        oImQ[j] <= oldIm[j*W +: W];
      end
    end
  end

  always_comb begin
    nextRe = clampLane(XW'(memRe[row][col]) + steer(nBitQ[row], nReQ[col])
                       - steer(oBitQ[row], oReQ[col]));
    nextIm = clampLane(XW'(memIm[row][col]) + steer(nBitQ[row], nImQ[col])
                       - steer(oBitQ[row], oImQ[col]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NBITS; i++)
        for (int j = 0; j < NSAMP; j++) begin
          memRe[i][j] <= '0;
          memIm[i][j] <= '0;
        end
    end else if (strb.wrEn) begin
      memRe[row][col] <= strb.zero ? '0 : nextRe;
      memIm[row][col] <= strb.zero ? '0 : nextIm;
    end
  end

  assign rdRe = memRe[rdRow][rdCol];
  assign rdIm = memIm[rdRow][rdCol];

  assert_zero_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.zero) |=>
      (memRe[$past(row)][$past(col)] == '0 && memIm[$past(row)][$past(col)] == '0));
endmodule

// File: rtl/sign_xcorr_acc.sv
module sign_xcorr_acc
  import xcorr_pkg::*;
#(
  parameter int NBITS = 4,
  parameter int NSAMP = 4,
  parameter int W     = 8,
  localparam int RW = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int CW = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               valid,
  input  logic               clear,
  input  logic [NBITS-1:0]   newBits,
  input  logic [NBITS-1:0]   oldBits,
  input  logic [NSAMP*W-1:0] newRe,
  input  logic [NSAMP*W-1:0] newIm,
  input  logic [NSAMP*W-1:0] oldRe,
  input  logic [NSAMP*W-1:0] oldIm,
  output logic               busy,
  input  logic [RW-1:0]      rdRow,
  input  logic [CW-1:0]      rdCol,
  output logic [W-1:0]       rdRe,
  output logic [W-1:0]       rdIm
);
  xc_strb_t      strb;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic signed [W-1:0] dRe, dIm;

  xcorr_ctrl #(.NBITS(NBITS), .NSAMP(NSAMP)) ctrl_i (
    .clk(clk), .rstN(rstN), .valid(valid), .clear(clear),
    .busy(busy), .row(row), .col(col), .strb(strb)
  );

  xcorr_dp #(.NBITS(NBITS), .NSAMP(NSAMP), .W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .row(row), .col(col),
    .newBits(newBits), .oldBits(oldBits),
    .newRe(newRe), .newIm(newIm), .oldRe(oldRe), .oldIm(oldIm),
    .rdRow(rdRow), .rdCol(rdCol), .rdRe(dRe), .rdIm(dIm)
  );

  assign rdRe = dRe;
  assign rdIm = dIm;

  assert_idle_read_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !valid && !clear) |=>
      (!$stable(rdRow) || !$stable(rdCol) || ($stable(rdRe) && $stable(rdIm))));
endmodule

// File: tb/sign_xcorr_acc_tb_top.sv
module sign_xcorr_acc_tb_top;
  localparam int NB = 4;
  localparam int NS = 4;
  localparam int W  = 8;
  localparam int M  = NB * NS;

  logic clk = 1'b0, rstN = 1'b0, valid = 1'b0, clear = 1'b0;
  logic [NB-1:0] newBits = '0, oldBits = '0;
  logic [NS*W-1:0] newRe = '0, newIm = '0, oldRe = '0, oldIm = '0;
  logic busy;
  logic [1:0] rdRow = '0, rdCol = '0;
  logic [W-1:0] rdRe, rdIm;

  int mRe [NB][NS];
  int mIm [NB][NS];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sign_xcorr_acc #(.NBITS(NB), .NSAMP(NS), .W(W)) dut_i (
    .clk(clk), .rstN(rstN), .valid(valid), .clear(clear),
    .newBits(newBits), .oldBits(oldBits),
    .newRe(newRe), .newIm(newIm), .oldRe(oldRe), .oldIm(oldIm),
    .busy(busy), .rdRow(rdRow), .rdCol(rdCol), .rdRe(rdRe), .rdIm(rdIm)
  );

  function automatic int clampRef(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int sgn(logic b);
    return b ? 1 : -1;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkMatrix(string req);
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NS; j++) begin
        rdRow = 2'(i); rdCol = 2'(j);
        #1;
        check(req, int'($signed(rdRe)), mRe[i][j]);
        check(req, int'($signed(rdIm)), mIm[i][j]);
      end
  endtask

  // busy compared against the expected pass length on every clock
  task automatic watchPass(string req, bit midPulse);
    for (int c = 0; c < M; c++) begin
      @(negedge clk);
      check(req, int'(busy), 1);
      if (midPulse && c == 2) begin
        valid = 1'b1; clear = 1'b1; newRe = '1; oldBits = ~oldBits;
      end else begin
        valid = 1'b0; clear = 1'b0;
      end
    end
    @(negedge clk);
    check(req, int'(busy), 0);
  endtask

  task automatic runUpdate(logic [NB-1:0] nb, logic [NB-1:0] ob,
                           int nr[NS], int ni[NS], int orr[NS], int oi[NS],
                           bit midPulse, string req);
    @(negedge clk);
    newBits = nb; oldBits = ob;
    for (int j = 0; j < NS; j++) begin
      newRe[j*W +: W] = W'(nr[j]); newIm[j*W +: W] = W'(ni[j]);
      oldRe[j*W +: W] = W'(orr[j]); oldIm[j*W +: W] = W'(oi[j]);
    end
    valid = 1'b1;
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NS; j++) begin
        mRe[i][j] = clampRef(mRe[i][j] + sgn(nb[i]) * nr[j] - sgn(ob[i]) * orr[j]);
        mIm[i][j] = clampRef(mIm[i][j] + sgn(nb[i]) * ni[j] - sgn(ob[i]) * oi[j]);
      end
    watchPass(req, midPulse);
    checkMatrix(req);
  endtask

  task automatic runClear(bit withValid);
    @(negedge clk);
    clear = 1'b1;
    valid = withValid;
    newBits = '1; newRe = {NS{8'h40}};
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NS; j++) begin mRe[i][j] = 0; mIm[i][j] = 0; end
    watchPass("R5", 0);
    checkMatrix("R5");
  endtask

  initial begin
    int a[NS], b[NS], c[NS], d[NS];
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NS; j++) begin mRe[i][j] = 0; mIm[i][j] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(busy), 0);
    checkMatrix("R1");

    // R3: plain sign-steered update, distinct values per column
    a = '{10, -20, 30, -40}; b = '{5, 6, -7, 8};
    c = '{1, 2, 3, 4};       d = '{-3, 0, 9, -1};
    runUpdate(4'b1010, 4'b0110, a, b, c, d, 0, "R3");
    // R2 + R3: second pass with other patterns
    a = '{-1, 7, 0, 15}; b = '{33, -33, 12, 1};
    c = '{0, -9, 4, 2};  d = '{2, 2, -2, -2};
    runUpdate(4'b0011, 4'b1100, a, b, c, d, 0, "R2");
    // R6: pulses and input changes mid-pass are ignored
    a = '{3, 3, -3, -3}; b = '{-8, 8, -8, 8};
    c = '{1, -1, 1, -1}; d = '{0, 5, 0, 5};
    runUpdate(4'b1111, 4'b0000, a, b, c, d, 1, "R6");
    // R4: drive to positive then negative limit
    a = '{127, 127, 100, 90}; b = '{-128, -128, -100, -90};
    c = '{-127, -128, -100, -90}; d = '{127, 127, 100, 90};
    for (int k = 0; k < 3; k++) runUpdate(4'b1111, 4'b1111, a, b, c, d, 0, "R4");
    for (int k = 0; k < 3; k++) runUpdate(4'b0000, 4'b0000, a, b, c, d, 0, "R4");
    // R5: clear, then clear together with valid
    runClear(0);
    a = '{50, -60, 70, -80}; b = '{1, 2, 3, 4};
    runUpdate(4'b0101, 4'b1001, a, b, a, b, 0, "R3");
    runClear(1);
    // R7: idle read stable over several cycles
    rdRow = 2'd1; rdCol = 2'd2;
    repeat (5) begin
      @(negedge clk);
      check("R7", int'($signed(rdRe)), mRe[1][2]);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nFails++; nChecks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule